// File: doc/BRIEF.md
# Banked Data Memory with Pointer Indirection

This block is the data memory front end of a small 8-bit controller core. A single port takes a direct address, a write enable and write data, and returns read data combinationally. The low end of the map holds the control register region. In it sit two pointer registers and two virtual indirect locations. Above the control registers comes a reserved gap, then general-purpose RAM. The RAM is banked: bank 0 holds RAM_BYTES bytes at GP_BASE and above, and bank 1 holds a second set of RAM_BYTES bytes at the same addresses.

A virtual indirect location has no storage of its own. Any access made to it is redirected to the address held in its pointer. The first pair (IND0/PTR0) always reaches bank 0. The second pair (IND1/PTR1) reaches the bank chosen by the `bank_sel` input. Direct accesses and IND0 accesses never look at `bank_sel`. The rest of the controller uses the pair to walk blocks of RAM without naming fixed addresses.

Top module: `dmem_indirect`

## Requirements
- R1: The map is fixed as follows. 00H is IND0, 01H is PTR0, 02H is IND1 and 03H is PTR1. Direct addresses from GP_BASE to GP_BASE+RAM_BYTES-1 read and write bank 0 RAM.
- R2: Addresses 04H to GP_BASE-1 cover the control locations not served here and the reserved gap. They read 00H, and writes to them change nothing.
- R3: Addresses at or above GP_BASE+RAM_BYTES read 00H and ignore writes. This holds whether the address is reached directly or through a pointer.
- R4: PTR0 and PTR1 are real registers. A direct write stores the data, and a direct read returns it.
- R5: An access to IND0 acts on bank 0 at the address in PTR0, whatever the value of bank_sel.
- R6: An access to IND1 acts on the address in PTR1. It uses bank 0 when bank_sel is 0 and bank 1 when bank_sel is 1.
- R7: An indirect access whose pointer holds 00H or 02H reads 00H and writes nothing. No RAM location and no pointer changes.
- R8: An indirect access whose pointer holds 01H or 03H reads or writes that pointer.
- R9: When RAM_BYTES is 88 or less, pointer bit 7 is not stored. It reads back as 1, and indirect addressing uses 0 for that bit. When RAM_BYTES is above 88, all 8 pointer bits are stored and used.
- R10: Writes take effect on the rising clock edge. Reads follow the address and pointer contents combinationally, so a pointer written in one cycle steers the indirect access in the next cycle.
- R11: A synchronous reset clears both pointers. RAM contents are left as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Direct data address |
| we | input | 1 | Write enable |
| wdata | input | 8 | Write data |
| bank_sel | input | 1 | RAM bank for IND1 accesses |
| rdata | output | 8 | Combinational read data |

## Verification
The main instance uses the defaults: RAM_BYTES=64 and GP_BASE=40 (28H), so RAM spans 28H to 67H. This makes pointer bit 7 unstored. It also makes reachable the edges of the RAM window, the reserved gap, and pointer values that point back into the indirect and pointer locations. A second instance uses RAM_BYTES=128, with RAM from 28H to A7H. That instance covers full 8-bit pointers and RAM above 7FH in both banks.

// File: rtl/dmem_indirect.sv
module dmem_indirect #(
  parameter int RAM_BYTES = 64,
  parameter int GP_BASE   = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] addr,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       bank_sel,
  output logic [7:0] rdata
);
  localparam logic [7:0] A_IND0 = 8'h00;
  localparam logic [7:0] A_PTR0 = 8'h01;
  localparam logic [7:0] A_IND1 = 8'h02;
  localparam logic [7:0] A_PTR1 = 8'h03;
  localparam int PW     = (RAM_BYTES <= 88) ? 7 : 8;
  localparam int GP_END = GP_BASE + RAM_BYTES;
  localparam int DEPTH  = 2 * RAM_BYTES;
  localparam int IW     = $clog2(DEPTH);

  logic [PW-1:0] ptr0, ptr1;
  logic [7:0]    ptr0_rd, ptr1_rd, ptr0_ea, ptr1_ea;
  logic [7:0]    mem [DEPTH];

  generate
    if (PW == 7) begin : g_narrow
      assign ptr0_rd = {1'b1, ptr0};
      assign ptr1_rd = {1'b1, ptr1};
      assign ptr0_ea = {1'b0, ptr0};
      assign ptr1_ea = {1'b0, ptr1};
    end else begin : g_full
      assign ptr0_rd = ptr0;
      assign ptr1_rd = ptr1;
      assign ptr0_ea = ptr0;
      assign ptr1_ea = ptr1;
    end
  endgenerate

  logic [7:0] tgt;
  logic       tbank, via_ind;

  always_comb begin
    case (addr)
      A_IND0:  begin tgt = ptr0_ea; tbank = 1'b0;     via_ind = 1'b1; end
      A_IND1:  begin tgt = ptr1_ea; tbank = bank_sel; via_ind = 1'b1; end
      default: begin tgt = addr;    tbank = 1'b0;     via_ind = 1'b0; end
    endcase
  end

  wire self_hit = via_ind && (tgt == A_IND0 || tgt == A_IND1);
  wire hit_p0   = !self_hit && tgt == A_PTR0;
  wire hit_p1   = !self_hit && tgt == A_PTR1;
  wire hit_ram  = !self_hit && (int'(tgt) >= GP_BASE) && (int'(tgt) < GP_END);

  logic [7:0]    ofs;
  logic [IW-1:0] ram_idx;
  assign ofs     = tgt - 8'(GP_BASE);
  assign ram_idx = (tbank ? IW'(RAM_BYTES) : IW'(0)) + IW'(ofs);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr0 <= '0;
      ptr1 <= '0;
    end else if (we) begin
      if (hit_p0) ptr0 <= wdata[PW-1:0];
      if (hit_p1) ptr1 <= wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && we && hit_ram) mem[ram_idx] <= wdata;
  end

  assign rdata = hit_p0  ? ptr0_rd :
                 hit_p1  ? ptr1_rd :
                 hit_ram ? mem[ram_idx] : 8'h00;
endmodule

// File: rtl/dmem_indirect_chk.sv
module dmem_indirect_chk #(
  parameter int PW      = 7,
  parameter int GP_BASE = 40,
  parameter int GP_END  = 104
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    addr,
  input logic          we,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic [PW-1:0] ptr0,
  input logic [PW-1:0] ptr1
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q) AST_PTR_CLEARED: assert (ptr0 == '0 && ptr1 == '0); // R11

  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr >= 8'h04 && int'(addr) < GP_BASE) |-> rdata == 8'h00); // R2

  AST_BEYOND_RAM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (int'(addr) >= GP_END) |-> rdata == 8'h00); // R3

  AST_PTR_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 8'h01) |=> ptr0 == $past(wdata[PW-1:0])); // R4

  AST_SELF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h00 && (8'(ptr0) == 8'h00 || 8'(ptr0) == 8'h02)) |-> rdata == 8'h00); // R7

  AST_SELF_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 8'h02 && 8'(ptr1) == 8'h02) |=> ($stable(ptr0) && $stable(ptr1))); // R7

  generate
    if (PW == 7) begin : g_b7
      AST_PTR_BIT7_HIGH: assert property (@(posedge clk) disable iff (rst)
        (addr == 8'h01 || addr == 8'h03) |-> rdata[7]); // R9
    end
  endgenerate
endmodule

bind dmem_indirect dmem_indirect_chk #(.PW(PW), .GP_BASE(GP_BASE), .GP_END(GP_END)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata),
  .rdata(rdata), .ptr0(ptr0), .ptr1(ptr1)
);

// File: tb/dmem_indirect_tb.sv
module dmem_indirect_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, we = 1'b0, bank_sel = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       w_rst = 1'b1, w_we = 1'b0, w_bank = 1'b0;
  logic [7:0] w_addr = '0, w_wdata = '0, w_rdata;

  dmem_indirect u_dut (.clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata),
                       .bank_sel(bank_sel), .rdata(rdata));
  dmem_indirect #(.RAM_BYTES(128), .GP_BASE(40)) u_dut_wide (
    .clk(clk), .rst(w_rst), .addr(w_addr), .we(w_we), .wdata(w_wdata),
    .bank_sel(w_bank), .rdata(w_rdata));

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // {req[3:0], we, addr, wdata, bank, chk, exp}
  localparam int NV = 48;
  localparam logic [30:0] VEC [NV] = '{
    {4'd9,  1'b0, 8'h01, 8'h00, 1'b0, 1'b1, 8'h80}, // R9 R11
    {4'd9,  1'b0, 8'h03, 8'h00, 1'b0, 1'b1, 8'h80}, // R9
    {4'd1,  1'b1, 8'h30, 8'h11, 1'b0, 1'b0, 8'h00}, // R1
    {4'd1,  1'b0, 8'h30, 8'h00, 1'b0, 1'b1, 8'h11}, // R1
    {4'd4,  1'b1, 8'h01, 8'h30, 1'b0, 1'b1, 8'h80}, // R4
    {4'd4,  1'b0, 8'h01, 8'h00, 1'b0, 1'b1, 8'hB0}, // R4
    {4'd5,  1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 8'h11}, // R5
    {4'd4,  1'b1, 8'h03, 8'h30, 1'b0, 1'b1, 8'h80}, // R4
    {4'd6,  1'b0, 8'h02, 8'h00, 1'b0, 1'b1, 8'h11}, // R6
    {4'd6,  1'b1, 8'h02, 8'h22, 1'b1, 1'b0, 8'h00}, // R6
    {4'd6,  1'b0, 8'h02, 8'h00, 1'b1, 1'b1, 8'h22}, // R6
    {4'd6,  1'b0, 8'h30, 8'h00, 1'b0, 1'b1, 8'h11}, // R6
    {4'd5,  1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h11}, // R5
    {4'd5,  1'b1, 8'h00, 8'h33, 1'b1, 1'b1, 8'h11}, // R5
    {4'd5,  1'b0, 8'h30, 8'h00, 1'b0, 1'b1, 8'h33}, // R5
    {4'd5,  1'b0, 8'h02, 8'h00, 1'b1, 1'b1, 8'h22}, // R5
    {4'd2,  1'b1, 8'h10, 8'h55, 1'b0, 1'b1, 8'h00}, // R2
    {4'd2,  1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 8'h00}, // R2
    {4'd3,  1'b1, 8'h70, 8'h66, 1'b0, 1'b1, 8'h00}, // R3
    {4'd3,  1'b0, 8'h70, 8'h00, 1'b0, 1'b1, 8'h00}, // R3
    {4'd4,  1'b1, 8'h01, 8'h7F, 1'b0, 1'b1, 8'hB0}, // R4
    {4'd3,  1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00}, // R3
    {4'd9,  1'b1, 8'h01, 8'hB0, 1'b0, 1'b1, 8'hFF}, // R9
    {4'd9,  1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h33}, // R9
    {4'd7,  1'b1, 8'h01, 8'h00, 1'b0, 1'b1, 8'hB0}, // R7
    {4'd7,  1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00}, // R7
    {4'd7,  1'b1, 8'h00, 8'h44, 1'b0, 1'b1, 8'h00}, // R7
    {4'd7,  1'b0, 8'h01, 8'h00, 1'b0, 1'b1, 8'h80}, // R7
    {4'd7,  1'b1, 8'h01, 8'h02, 1'b0, 1'b1, 8'h80}, // R7
    {4'd7,  1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00}, // R7
    {4'd8,  1'b1, 8'h03, 8'h01, 1'b0, 1'b1, 8'hB0}, // R8
    {4'd8,  1'b0, 8'h02, 8'h00, 1'b1, 1'b1, 8'h82}, // R8
    {4'd8,  1'b1, 8'h02, 8'h31, 1'b1, 1'b1, 8'h82}, // R8
    {4'd8,  1'b0, 8'h01, 8'h00, 1'b0, 1'b1, 8'hB1}, // R8
    {4'd10, 1'b1, 8'h31, 8'h77, 1'b0, 1'b0, 8'h00}, // R10
    {4'd10, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h77}, // R10
    {4'd2,  1'b1, 8'h27, 8'h99, 1'b0, 1'b1, 8'h00}, // R2
    {4'd2,  1'b0, 8'h27, 8'h00, 1'b0, 1'b1, 8'h00}, // R2
    {4'd1,  1'b1, 8'h28, 8'hA1, 1'b0, 1'b0, 8'h00}, // R1
    {4'd1,  1'b0, 8'h28, 8'h00, 1'b0, 1'b1, 8'hA1}, // R1
    {4'd1,  1'b1, 8'h67, 8'h5A, 1'b0, 1'b0, 8'h00}, // R1
    {4'd1,  1'b0, 8'h67, 8'h00, 1'b0, 1'b1, 8'h5A}, // R1
    {4'd3,  1'b1, 8'h68, 8'h5B, 1'b0, 1'b1, 8'h00}, // R3
    {4'd3,  1'b0, 8'h68, 8'h00, 1'b0, 1'b1, 8'h00}, // R3
    {4'd7,  1'b1, 8'h03, 8'h02, 1'b0, 1'b1, 8'h81}, // R7
    {4'd7,  1'b1, 8'h02, 8'hEE, 1'b1, 1'b1, 8'h00}, // R7
    {4'd7,  1'b0, 8'h03, 8'h00, 1'b0, 1'b1, 8'h82}, // R7
    {4'd7,  1'b0, 8'h01, 8'h00, 1'b0, 1'b1, 8'hB1}  // R7
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    we = w; addr = a; wdata = d; bank_sel = b;
    #2;
  endtask

  task automatic wstep(input logic w, input logic [7:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    w_we = w; w_addr = a; w_wdata = d; w_bank = b;
    #2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0; w_rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][26], VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
      if (VEC[i][8]) check(int'(VEC[i][30:27]), rdata, VEC[i][7:0]);
    end

    // R11: reset clears pointers, RAM survives
    @(negedge clk); we = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    step(1'b0, 8'h01, 8'h00, 1'b0); check(11, rdata, 8'h80);
    step(1'b0, 8'h03, 8'h00, 1'b0); check(11, rdata, 8'h80);
    step(1'b0, 8'h30, 8'h00, 1'b0); check(11, rdata, 8'h33);
    step(1'b0, 8'h28, 8'h00, 1'b0); check(11, rdata, 8'hA1);

    // R10: pointer written on one edge steers the very next cycle
    step(1'b1, 8'h03, 8'h67, 1'b0);
    step(1'b0, 8'h02, 8'h00, 1'b0); check(10, rdata, 8'h5A);

    // R9 wide: all eight pointer bits kept, RAM above 7FH in both banks
    wstep(1'b1, 8'h01, 8'hA5, 1'b0);
    wstep(1'b0, 8'h01, 8'h00, 1'b0); check(9, w_rdata, 8'hA5);
    wstep(1'b1, 8'hA0, 8'h3C, 1'b1);
    wstep(1'b1, 8'h03, 8'hA0, 1'b0);
    wstep(1'b1, 8'h02, 8'h4D, 1'b1);
    wstep(1'b0, 8'h02, 8'h00, 1'b1); check(9, w_rdata, 8'h4D);
    wstep(1'b0, 8'hA0, 8'h00, 1'b1); check(6, w_rdata, 8'h3C);
    wstep(1'b1, 8'hA8, 8'h12, 1'b0);
    wstep(1'b0, 8'hA8, 8'h00, 1'b0); check(3, w_rdata, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule